// File: doc/BRIEF.md
# Processor Status Flag Register

This block holds the eight condition and control flags of a small processor core and presents them both as one packed byte and as eight separate wires. Three ways of changing it exist: a byte load that replaces every flag at once, a single-flag load that picks one flag by its 3-bit position and writes one bit into it, and a result strobe that carries the ALU output. On a result strobe the block derives the negative, zero and sign flags itself. The sign flag is the exclusive-or of the new negative flag and the overflow flag already held, so overflow must be written into place (by a single-flag or byte load) before the result that depends on it arrives.

Carry, half-carry and overflow are produced elsewhere and reach the register only through the two load paths. All updates are registered on the rising clock edge. The state clears asynchronously when the active-low reset is asserted.

Top module: `status_flags_unit`

## Requirements
- R1: `status_o` packs the flags with interrupt-enable at bit 7, transfer at bit 6, half-carry at bit 5, sign at bit 4, overflow at bit 3, negative at bit 2, zero at bit 1 and carry at bit 0; each single-flag output equals its bit of `status_o`.
- R2: While `rst_ni` is low every flag is 0, and after release the register stays 0 until a load or result strobe occurs.
- R3: With `load_all_i` high at a clock edge, all eight flags take `load_byte_i` in the bit order of R1.
- R4: With `res_vld_i` high (and no byte load), the negative flag takes the most significant bit of `res_data_i`.
- R5: With `res_vld_i` high (and no byte load), the zero flag becomes 1 when `res_data_i` is all zeros and 0 otherwise.
- R6: With `res_vld_i` high (and no byte load), the sign flag becomes the new negative value xor the overflow flag held before that edge.
- R7: A result strobe leaves carry, half-carry, overflow, transfer and interrupt-enable unchanged.
- R8: A byte load in the same cycle as a result strobe and/or a single-flag load wins: the register takes `load_byte_i` exactly.
- R9: With `load_bit_i` high (and no byte load), the flag at bit position `bit_sel_i` (0 = carry … 7 = interrupt-enable, as in R1) takes `bit_val_i`; the other flags that no result strobe touches keep their values.
- R10: A single-flag load and a result strobe in the same cycle both apply; on a flag addressed by both, the single-flag load wins, and the sign flag still uses the overflow value held before the edge even when overflow is written in that cycle.
- R11: With no strobe asserted the register holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| load_all_i | input | 1 | Load the whole register from `load_byte_i` |
| load_byte_i | input | 8 | Packed flag byte for a byte load |
| load_bit_i | input | 1 | Load one flag |
| bit_sel_i | input | 3 | Bit position of the flag to load |
| bit_val_i | input | 1 | Value for the single-flag load |
| res_vld_i | input | 1 | ALU result strobe |
| res_data_i | input | 8 | ALU result |
| status_o | output | 8 | Packed flags |
| irq_en_o | output | 1 | Interrupt-enable flag |
| xfer_o | output | 1 | Transfer flag |
| half_c_o | output | 1 | Half-carry flag |
| sign_o | output | 1 | Sign flag |
| ovf_o | output | 1 | Overflow flag |
| neg_o | output | 1 | Negative flag |
| zero_o | output | 1 | Zero flag |
| carry_o | output | 1 | Carry flag |

## Verification
The hardest situation to reach is the same-edge collision where overflow is rewritten by a single-flag load while a result strobe recomputes the sign, since only the old overflow may feed the sign. The stimulus first parks overflow at a known value, then fires the result strobe together with a single-flag load of the opposite overflow value, and repeats with the negative flag itself addressed so both precedence rules of R10 are seen. Byte loads are also stacked on top of both other strobes to expose R8.

// File: rtl/sf_pkg.sv
package sf_pkg;
  localparam int FLAG_CNT  = 8;
  localparam int FLAG_IDX_W = $clog2(FLAG_CNT);

  // bit positions inside the packed status byte
  localparam int FLG_C = 0;
  localparam int FLG_Z = 1;
  localparam int FLG_N = 2;
  localparam int FLG_V = 3;
  localparam int FLG_S = 4;
  localparam int FLG_H = 5;
  localparam int FLG_T = 6;
  localparam int FLG_I = 7;

  typedef logic [FLAG_CNT-1:0] flags_t;
endpackage

// File: rtl/sf_result_eval.sv
module sf_result_eval #(
  parameter int RES_W = 8
) (
  input  logic [RES_W-1:0] res_i,
  input  logic             ovf_held_i,
  output logic             neg_o,
  output logic             zero_o,
  output logic             sign_o
);
  always_comb begin
    neg_o  = res_i[RES_W-1];
    zero_o = ~|res_i;
    // sign uses the overflow already stored, not a fresh one
    sign_o = res_i[RES_W-1] ^ ovf_held_i;
  end
endmodule

// File: rtl/sf_bit_decode.sv
module sf_bit_decode #(
  parameter int N     = 8,
  parameter int IDX_W = $clog2(N)
) (
  input  logic             en_i,
  input  logic [IDX_W-1:0] idx_i,
  output logic [N-1:0]     mask_o
);
  for (genvar g = 0; g < N; g++) begin : g_dec
    assign mask_o[g] = en_i && (idx_i == IDX_W'(g));
  end
endmodule

// File: rtl/sf_next_state.sv
module sf_next_state
  import sf_pkg::*;
(
  input  flags_t cur_i,
  input  logic   load_all_i,
  input  flags_t load_byte_i,
  input  flags_t bit_mask_i,
  input  logic   bit_val_i,
  input  logic   res_vld_i,
  input  logic   neg_i,
  input  logic   zero_i,
  input  logic   sign_i,
  output flags_t nxt_o
);
  for (genvar g = 0; g < FLAG_CNT; g++) begin : g_bit
    logic res_upd;
    logic res_val;

    if (g == FLG_N) begin : g_n
      assign res_upd = res_vld_i;
      assign res_val = neg_i;
    end else if (g == FLG_Z) begin : g_z
      assign res_upd = res_vld_i;
      assign res_val = zero_i;
    end else if (g == FLG_S) begin : g_s
      assign res_upd = res_vld_i;
      assign res_val = sign_i;
    end else begin : g_keep
      assign res_upd = 1'b0;
      assign res_val = 1'b0;
    end

    // priority: byte load > single-flag load > result update
    always_comb begin
      nxt_o[g] = cur_i[g];
      if (res_upd)       nxt_o[g] = res_val;
      if (bit_mask_i[g]) nxt_o[g] = bit_val_i;
      if (load_all_i)    nxt_o[g] = load_byte_i[g];
    end
  end
endmodule

// File: rtl/status_flags_unit.sv
module status_flags_unit
  import sf_pkg::*;
#(
  parameter int RES_W = 8
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  load_all_i,
  input  logic [FLAG_CNT-1:0]   load_byte_i,
  input  logic                  load_bit_i,
  input  logic [FLAG_IDX_W-1:0] bit_sel_i,
  input  logic                  bit_val_i,
  input  logic                  res_vld_i,
  input  logic [RES_W-1:0]      res_data_i,
  output logic [FLAG_CNT-1:0]   status_o,
  output logic                  irq_en_o,
  output logic                  xfer_o,
  output logic                  half_c_o,
  output logic                  sign_o,
  output logic                  ovf_o,
  output logic                  neg_o,
  output logic                  zero_o,
  output logic                  carry_o
);
  flags_t flags_q, flags_d, bit_mask;
  logic   res_neg, res_zero, res_sign;

  sf_result_eval #(.RES_W(RES_W)) u_eval (
    .res_i      (res_data_i),
    .ovf_held_i (flags_q[FLG_V]),
    .neg_o      (res_neg),
    .zero_o     (res_zero),
    .sign_o     (res_sign)
  );

  sf_bit_decode #(.N(FLAG_CNT), .IDX_W(FLAG_IDX_W)) u_dec (
    .en_i   (load_bit_i),
    .idx_i  (bit_sel_i),
    .mask_o (bit_mask)
  );

  sf_next_state u_nxt (
    .cur_i       (flags_q),
    .load_all_i  (load_all_i),
    .load_byte_i (load_byte_i),
    .bit_mask_i  (bit_mask),
    .bit_val_i   (bit_val_i),
    .res_vld_i   (res_vld_i),
    .neg_i       (res_neg),
    .zero_i      (res_zero),
    .sign_i      (res_sign),
    .nxt_o       (flags_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flags_q <= '0;
    else         flags_q <= flags_d;
  end

  assign status_o = flags_q;
  assign irq_en_o = flags_q[FLG_I];
  assign xfer_o   = flags_q[FLG_T];
  assign half_c_o = flags_q[FLG_H];
  assign sign_o   = flags_q[FLG_S];
  assign ovf_o    = flags_q[FLG_V];
  assign neg_o    = flags_q[FLG_N];
  assign zero_o   = flags_q[FLG_Z];
  assign carry_o  = flags_q[FLG_C];
endmodule

// File: rtl/sf_status_chk.sv
module sf_status_chk
  import sf_pkg::*;
#(
  parameter int RES_W = 8
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  load_all_i,
  input logic [FLAG_CNT-1:0]   load_byte_i,
  input logic                  load_bit_i,
  input logic [FLAG_IDX_W-1:0] bit_sel_i,
  input logic                  bit_val_i,
  input logic                  res_vld_i,
  input logic [RES_W-1:0]      res_data_i,
  input logic [FLAG_CNT-1:0]   status_o
);
  logic res_only;
  assign res_only = res_vld_i && !load_all_i;

  a_r2_reset_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> status_o == '0);

  a_r3_byte_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_all_i |=> status_o == $past(load_byte_i));

  a_r4_neg_msb: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_only && !(load_bit_i && bit_sel_i == FLAG_IDX_W'(FLG_N))
    |=> status_o[FLG_N] == $past(res_data_i[RES_W-1]));

  a_r5_zero_detect: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_only && !(load_bit_i && bit_sel_i == FLAG_IDX_W'(FLG_Z))
    |=> status_o[FLG_Z] == ($past(res_data_i) == '0));

  a_r6_sign_old_ovf: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_only && !(load_bit_i && bit_sel_i == FLAG_IDX_W'(FLG_S))
    |=> status_o[FLG_S] == $past(res_data_i[RES_W-1] ^ status_o[FLG_V]));

  a_r7_others_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_only && !load_bit_i
    |=> $stable(status_o[FLG_I:FLG_H]) && $stable(status_o[FLG_V])
        && $stable(status_o[FLG_C]));

  a_r9_bit_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_bit_i && !load_all_i |=> status_o[$past(bit_sel_i)] == $past(bit_val_i));

  a_r11_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_all_i && !load_bit_i && !res_vld_i |=> $stable(status_o));
endmodule

bind status_flags_unit sf_status_chk #(.RES_W(RES_W)) u_sf_chk (.*);

// File: tb/tb_status_flags_unit.sv
module tb_status_flags_unit;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       load_all_i = 1'b0;
  logic [7:0] load_byte_i = '0;
  logic       load_bit_i = 1'b0;
  logic [2:0] bit_sel_i = '0;
  logic       bit_val_i = 1'b0;
  logic       res_vld_i = 1'b0;
  logic [7:0] res_data_i = '0;
  logic [7:0] status_o;
  logic irq_en_o, xfer_o, half_c_o, sign_o, ovf_o, neg_o, zero_o, carry_o;

  status_flags_unit dut (.*);

  always #10 clk_i = ~clk_i;

  typedef struct {
    logic [7:0] exp;
    string      tag;
  } item_t;

  item_t      sb_q[$];
  int         n_chk = 0;
  int         n_fail = 0;
  logic [7:0] mdl = '0;

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  // driver: apply one cycle of stimulus, push the expected state
  task automatic step(input string tag, input logic wa, input logic [7:0] wd,
                      input logic wb, input logic [2:0] bi, input logic bv,
                      input logic rv, input logic [7:0] rd);
    logic [7:0] nxt;
    @(negedge clk_i);
    load_all_i = wa; load_byte_i = wd;
    load_bit_i = wb; bit_sel_i = bi; bit_val_i = bv;
    res_vld_i = rv; res_data_i = rd;
    nxt = mdl;
    if (rv) begin
      nxt[2] = rd[7];
      nxt[1] = (rd == 8'h00);
      nxt[4] = rd[7] ^ mdl[3];
    end
    if (wb) nxt[bi] = bv;
    if (wa) nxt = wd;
    @(posedge clk_i);
    #1;
    mdl = nxt;
    sb_q.push_back('{exp: nxt, tag: tag});
    load_all_i = 1'b0; load_bit_i = 1'b0; res_vld_i = 1'b0;
  endtask

  // monitor
  always @(negedge clk_i) begin
    if (sb_q.size() > 0) begin
      item_t it;
      it = sb_q.pop_front();
      check(it.tag, status_o, it.exp);
      check({"R1 ", it.tag},
            {irq_en_o, xfer_o, half_c_o, sign_o, ovf_o, neg_o, zero_o, carry_o}, it.exp);
    end
  end

  initial begin
    #4_000_000;
    n_fail++; n_chk++;
    $display("FAIL watchdog actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #25;
    check("R2 in reset", status_o, 8'h00);
    @(negedge clk_i); rst_ni = 1'b1;
    step("R2 idle after reset", 0, 8'h00, 0, 3'd0, 0, 0, 8'h00);

    step("R3 byte load ff", 1, 8'hFF, 0, 3'd0, 0, 0, 8'h00);
    step("R3 byte load a5", 1, 8'hA5, 0, 3'd0, 0, 0, 8'h00);
    step("R11 hold", 0, 8'h00, 0, 3'd0, 0, 0, 8'h00);
    step("R11 hold again", 0, 8'h00, 0, 3'd0, 0, 0, 8'h00);

    // overflow held = 1
    step("R3 clear", 1, 8'h00, 0, 3'd0, 0, 0, 8'h00);
    step("R9 set ovf", 0, 8'h00, 1, 3'd3, 1, 0, 8'h00);
    step("R4 R6 neg result ovf1", 0, 8'h00, 0, 3'd0, 0, 1, 8'h80);
    step("R5 R6 zero result ovf1", 0, 8'h00, 0, 3'd0, 0, 1, 8'h00);
    step("R9 clr ovf", 0, 8'h00, 1, 3'd3, 0, 0, 8'h00);
    step("R4 R5 R6 pos result ovf0", 0, 8'h00, 0, 3'd0, 0, 1, 8'h7F);
    step("R4 R6 neg result ovf0", 0, 8'h00, 0, 3'd0, 0, 1, 8'hC3);

    // R7: preload I,T,H,V,C = 1, then results
    step("R3 preload e9", 1, 8'hE9, 0, 3'd0, 0, 0, 8'h00);
    step("R7 zero result keeps ithvc", 0, 8'h00, 0, 3'd0, 0, 1, 8'h00);
    step("R7 neg result keeps ithvc", 0, 8'h00, 0, 3'd0, 0, 1, 8'h81);
    step("R3 preload 16", 1, 8'h16, 0, 3'd0, 0, 0, 8'h00);
    step("R7 result keeps zeros", 0, 8'h00, 0, 3'd0, 0, 1, 8'h01);

    // R8: byte load beats everything
    step("R8 load vs result", 1, 8'h5A, 0, 3'd0, 0, 1, 8'h00);
    step("R8 load vs bit", 1, 8'h3C, 1, 3'd7, 1, 0, 8'h00);
    step("R8 load vs both", 1, 8'hC0, 1, 3'd2, 1, 1, 8'h80);

    // R9: walk every position
    step("R3 clear", 1, 8'h00, 0, 3'd0, 0, 0, 8'h00);
    for (int i = 0; i < 8; i++) step("R9 set walk", 0, 8'h00, 1, 3'(i), 1, 0, 8'h00);
    for (int i = 7; i >= 0; i--) step("R9 clr walk", 0, 8'h00, 1, 3'(i), 0, 0, 8'h00);

    // R10: collisions of single-flag load and result strobe
    step("R3 clear", 1, 8'h00, 0, 3'd0, 0, 0, 8'h00);
    step("R10 ovf write uses old ovf0", 0, 8'h00, 1, 3'd3, 1, 1, 8'h80);
    step("R10 ovf write uses old ovf1", 0, 8'h00, 1, 3'd3, 0, 1, 8'h80);
    step("R10 neg bit wins", 0, 8'h00, 1, 3'd2, 0, 1, 8'h80);
    step("R10 zero bit wins", 0, 8'h00, 1, 3'd1, 0, 1, 8'h00);
    step("R10 sign bit wins", 0, 8'h00, 1, 3'd4, 1, 1, 8'h00);
    step("R10 carry bit plus result", 0, 8'h00, 1, 3'd0, 1, 1, 8'h40);
    step("R11 hold after collide", 0, 8'h00, 0, 3'd0, 0, 0, 8'h00);

    // mid-run asynchronous reset
    step("R3 load ff", 1, 8'hFF, 0, 3'd0, 0, 0, 8'h00);
    @(negedge clk_i);
    @(negedge clk_i);
    #5 rst_ni = 1'b0;
    #1 check("R2 async clear", status_o, 8'h00);
    mdl = '0;
    @(negedge clk_i); rst_ni = 1'b1;
    step("R2 stays clear", 0, 8'h00, 0, 3'd0, 0, 0, 8'h00);

    repeat (3) @(negedge clk_i);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule